// File: doc/BRIEF.md
# Three-Phase 16-bit RISC Core

This block is a small 16-bit processor with separate instruction and data memories. Each instruction takes exactly three clock cycles. In the first cycle the program counter is placed on the instruction port. In the second cycle the fetched word arrives and is decoded, and a load's address goes out on the data port. In the third cycle the instruction takes effect: a register is written, the data memory is written, or the program counter is redirected. There is no overlap between instructions, so there are no hazards to resolve.

The core holds eight 16-bit registers. Register 0 always reads as zero. It has an adder/subtractor/AND unit and decodes eight operations from a 3-bit opcode at the top of each word. Both memory ports address 256 words with a registered read, so the read data appears one clock after the address. The program counter is 16 bits wide and only its low bits reach the instruction port, so code addresses alias modulo the memory size.

Top module: `tri_phase_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pc_o` to 0, sets `phase_o` to 0 (fetch) and clears registers 1 to 7. Memory contents are not touched.
- R2: `phase_o` follows the order 0 (fetch), 1 (decode), 2 (execute) and then back to 0, one clock each. The value 3 never appears.
- R3: An opcode of 000 in bits 15:13 (load immediate) writes the 8-bit field in bits 9:2, zero-extended, to the register selected by bits 12:10.
- R4: Opcodes 001, 010 and 011 write, to the register in bits 12:10, the sum, the difference or the bitwise AND of the registers in bits 9:7 and 6:4 (first operand minus second for 010), modulo 2^16.
- R5: Register 0 reads as zero as an operand or an address, and writing to it has no effect.
- R6: Opcode 100 (load) writes data memory word `Rs1 mod 256` to the register in bits 12:10, with Rs1 taken from bits 9:7. The address goes out during decode, and the returned word is written at the end of execute.
- R7: Opcode 101 (store) raises `dmem_we` only during execute. It drives `dmem_addr` with the low 8 bits of the register in bits 12:10 and drives `dmem_wdata` with the register in bits 9:7.
- R8: Opcode 110 compares the registers in bits 12:10 and 9:7. When they are equal, the PC becomes its own address plus the 7-bit field in bits 6:0, sign-extended. When they differ, the PC becomes PC+1. This opcode never writes a register.
- R9: Opcode 111 loads the PC with bits 12:0, zero-extended to 16 bits.
- R10: Every other opcode sets the PC to PC+1 at the end of execute. The PC holds its value during fetch and decode, and `imem_addr` carries the low 8 bits of the PC.
- R11: After four straight-line instructions, that is 12 clocks after reset is released, `pc_o` is 4 and `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction memory word address |
| imem_rdata | input | 16 | Instruction word, registered one clock after the address |
| dmem_addr | output | 8 | Data memory word address |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 16 | Data memory read word, registered one clock after the address |
| pc_o | output | 16 | Program counter |
| phase_o | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute |

## Verification
The bench builds the core with its default 8-bit memory address, which gives 256-word memories. At this size, 16-bit register values such as 0x01FE wrap onto memory word 254, and a jump to 0x1F40 runs code stored at instruction word 64 while `pc_o` keeps the full 16-bit value. The test program exercises forward and backward branches, including a three-pass loop closed by a negative offset. It also applies a reset in the middle of an instruction and checks that the core restarts cleanly.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int WORD_W = 16;
  localparam int RIDX_W = 3;
  localparam int NREG   = 1 << RIDX_W;
  localparam int OFF_W  = 7;
  localparam int IMM_W  = 8;
  localparam int JMP_W  = 13;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_LDI = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_AND = 3'd3,
    OP_LD  = 3'd4, OP_ST  = 3'd5, OP_BEQ = 3'd6, OP_JMP = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0, PH_DECODE = 2'd1, PH_EXEC = 2'd2
  } phase_e;

  function automatic word_t zext_imm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W){1'b0}}, imm};
  endfunction

  function automatic word_t zext_jmp(input logic [JMP_W-1:0] a);
    return {{(WORD_W-JMP_W){1'b0}}, a};
  endfunction

  function automatic word_t branch_target(input word_t pc, input logic [OFF_W-1:0] off);
    return pc + {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic is_alu_op(input opcode_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
  endfunction
endpackage

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);
  logic [NREG*W-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i == 0) begin : g_zero
      assign flat[0 +: W] = '0;
    end else begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (we && (waddr == AW'(i))) q <= wdata;
      end
      assign flat[i*W +: W] = q;
    end
  end

  assign ra_data = flat[ra_addr*W +: W];
  assign rb_data = flat[rb_addr*W +: W];
endmodule

// File: rtl/tpc_alu.sv
module tpc_alu #(
  parameter int W = 16
) (
  input  tpc_pkg::opcode_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y,
  output logic             zero
);
  import tpc_pkg::*;
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      default: y = a - b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect,
  input  logic [W-1:0]     target,
  output tpc_pkg::phase_e  phase,
  output logic [W-1:0]     pc
);
  import tpc_pkg::*;
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= '0;
    end else begin
      case (phase)
        PH_FETCH:  phase <= PH_DECODE;
        PH_DECODE: phase <= PH_EXEC;
        PH_EXEC: begin
          phase <= PH_FETCH;
          pc    <= redirect ? target : pc + W'(1);
        end
        default:   phase <= PH_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/tri_phase_core.sv
module tri_phase_core #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [MEM_AW-1:0] imem_addr,
  input  logic [15:0]       imem_rdata,
  output logic [MEM_AW-1:0] dmem_addr,
  output logic [15:0]       dmem_wdata,
  output logic              dmem_we,
  input  logic [15:0]       dmem_rdata,
  output logic [15:0]       pc_o,
  output logic [1:0]        phase_o
);
  import tpc_pkg::*;

  phase_e            phase;
  word_t             pc;
  word_t             ir_q;
  opcode_e           op_x;
  opcode_e           alu_op;
  logic              in_dec, in_exe, arith;
  logic [RIDX_W-1:0] ra_sel, rb_sel, rd_sel;
  word_t             ra_data, rb_data, alu_y, wb_data;
  logic              alu_zero, rf_we, redirect;
  word_t             target;

  // instruction register: captured when the registered fetch word is present
  always_ff @(posedge clk) begin
    if (rst) ir_q <= '0;
    else if (phase == PH_DECODE) ir_q <= imem_rdata;
  end

  assign op_x   = opcode_e'(ir_q[15:13]);
  assign in_dec = (phase == PH_DECODE);
  assign in_exe = (phase == PH_EXEC);
  assign arith  = is_alu_op(op_x);
  assign rd_sel = ir_q[12:10];

  // port A: load address in decode; first operand or address/compare register in execute
  assign ra_sel = in_dec ? imem_rdata[9:7] : (arith ? ir_q[9:7] : ir_q[12:10]);
  assign rb_sel = arith ? ir_q[6:4] : ir_q[9:7];

  tpc_regfile #(.W(WORD_W), .NREG(NREG)) rf_i (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rd_sel), .wdata(wb_data),
    .ra_addr(ra_sel), .ra_data(ra_data), .rb_addr(rb_sel), .rb_data(rb_data)
  );

  assign alu_op = (op_x == OP_BEQ) ? OP_SUB : op_x;

  tpc_alu #(.W(WORD_W)) alu_i (
    .op(alu_op), .a(ra_data), .b(rb_data), .y(alu_y), .zero(alu_zero)
  );

  always_comb begin
    case (op_x)
      OP_LDI:  wb_data = zext_imm(ir_q[9:2]);
      OP_LD:   wb_data = dmem_rdata;
      default: wb_data = alu_y;
    endcase
  end

  assign rf_we    = in_exe && (arith || op_x == OP_LDI || op_x == OP_LD);
  assign redirect = (op_x == OP_JMP) || (op_x == OP_BEQ && alu_zero);
  assign target   = (op_x == OP_JMP) ? zext_jmp(ir_q[12:0]) : branch_target(pc, ir_q[6:0]);

  tpc_seq #(.W(WORD_W)) seq_i (
    .clk(clk), .rst(rst), .redirect(redirect), .target(target),
    .phase(phase), .pc(pc)
  );

  assign imem_addr  = pc[MEM_AW-1:0];
  assign dmem_addr  = ra_data[MEM_AW-1:0];
  assign dmem_wdata = rb_data;
  assign dmem_we    = in_exe && (op_x == OP_ST);
  assign pc_o       = pc;
  assign phase_o    = phase;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  phase,
  input logic [15:0] pc,
  input logic        dmem_we,
  input logic [15:0] ir,
  input logic        redirect,
  input logic        rf_we,
  input logic [2:0]  ra_addr,
  input logic [15:0] ra_data
);
  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |=> phase == 2'd1);
  p_decode_to_exec_r2: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd1 |=> phase == 2'd2);
  p_exec_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd2 |=> phase == 2'd0);
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd2 |=> $stable(pc));
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !redirect) |=> pc == $past(pc) + 16'd1);
  p_jmp_target_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && ir[15:13] == 3'b111) |=> pc == {3'b000, $past(ir[12:0])});
  p_store_exec_only_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> phase == 2'd2);
  p_zero_reg_r5: assert property (@(posedge clk) disable iff (rst)
    ra_addr == 3'd0 |-> ra_data == 16'd0);
  p_beq_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && ir[15:13] == 3'b110) |-> !rf_we);
endmodule

bind tri_phase_core tpc_checker chk_i (
  .clk(clk), .rst(rst), .phase(phase_o), .pc(pc_o), .dmem_we(dmem_we),
  .ir(ir_q), .redirect(redirect), .rf_we(rf_we), .ra_addr(ra_sel), .ra_data(ra_data)
);

// File: tb/tri_phase_core_tb_top.sv
`timescale 1ns/1ps
module tri_phase_core_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr, dmem_addr;
  logic [15:0] imem_rdata, dmem_rdata, dmem_wdata, pc_o;
  logic        dmem_we;
  logic [1:0]  phase_o;

  logic [15:0] imem [DEPTH];
  logic [15:0] dmem [DEPTH];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int m_pc = 0, m_phase = 0;
  int m_r [8];
  int refd [DEPTH];

  always #2.5 clk = ~clk;

  tri_phase_core dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .pc_o(pc_o), .phase_o(phase_o)
  );

  // environment memories: registered read
  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr];
    dmem_rdata <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] i_ldi(input int rd, input int imm);
    return 16'((0 << 13) + (rd << 10) + ((imm % 256) * 4));
  endfunction
  function automatic logic [15:0] i_rrr(input int op, input int rd, input int a, input int b);
    return 16'((op << 13) + (rd << 10) + (a << 7) + (b << 4));
  endfunction
  function automatic logic [15:0] i_ld(input int rd, input int a);
    return 16'((4 << 13) + (rd << 10) + (a << 7));
  endfunction
  function automatic logic [15:0] i_st(input int ar, input int dr);
    return 16'((5 << 13) + (ar << 10) + (dr << 7));
  endfunction
  function automatic logic [15:0] i_beq(input int a, input int b, input int off);
    return 16'((6 << 13) + (a << 10) + (b << 7) + ((off + 128) % 128));
  endfunction
  function automatic logic [15:0] i_jmp(input int adr);
    return 16'((7 << 13) + (adr % 8192));
  endfunction

  function automatic void m_wr(input int d, input int v);
    if (d != 0) m_r[d] = v % 65536;
  endfunction

  function automatic void m_reset();
    m_pc = 0; m_phase = 0;
    for (int k = 0; k < 8; k++) m_r[k] = 0;
  endfunction

  // advance the model by one clock edge
  function automatic void m_step(input bit r);
    int w, op, f1, f2, f3, npc, off;
    if (r) begin m_reset(); return; end
    if (m_phase < 2) begin m_phase++; return; end
    w  = int'(imem[m_pc % DEPTH]);
    op = (w >> 13) % 8; f1 = (w >> 10) % 8; f2 = (w >> 7) % 8; f3 = (w >> 4) % 8;
    npc = (m_pc + 1) % 65536;
    case (op)
      0: m_wr(f1, (w >> 2) % 256);
      1: m_wr(f1, m_r[f2] + m_r[f3]);
      2: m_wr(f1, m_r[f2] - m_r[f3] + 65536);
      3: m_wr(f1, m_r[f2] & m_r[f3]);
      4: m_wr(f1, refd[m_r[f2] % DEPTH]);
      5: refd[m_r[f1] % DEPTH] = m_r[f2];
      6: if (m_r[f1] == m_r[f2]) begin
           off = w % 128;
           if (off >= 64) off -= 128;
           npc = (m_pc + off + 65536) % 65536;
         end
      default: npc = w % 8192;
    endcase
    m_pc = npc;
    m_phase = 0;
  endfunction

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    int w, st;
    @(posedge clk);
    cyc++;
    m_step(rst);
    @(negedge clk);
    chk(int'(phase_o) == m_phase, "R2 phase", int'(phase_o), m_phase);
    chk(int'(pc_o) == m_pc, "R10 pc (R8/R9 redirect)", int'(pc_o), m_pc);
    chk(int'(imem_addr) == m_pc % DEPTH, "R10 imem_addr", int'(imem_addr), m_pc % DEPTH);
    w  = int'(imem[m_pc % DEPTH]);
    st = (m_phase == 2 && (w >> 13) == 5) ? 1 : 0;
    chk(int'(dmem_we) == st, "R7 dmem_we", int'(dmem_we), st);
    if (st == 1) begin
      chk(int'(dmem_addr) == m_r[(w >> 10) % 8] % DEPTH, "R7 store address",
          int'(dmem_addr), m_r[(w >> 10) % 8] % DEPTH);
      chk(int'(dmem_wdata) == m_r[(w >> 7) % 8], "R7 store data",
          int'(dmem_wdata), m_r[(w >> 7) % 8]);
    end
    if (m_phase == 1 && (int'(imem[m_pc % DEPTH]) >> 13) == 4)
      chk(int'(dmem_addr) == m_r[(w >> 7) % 8] % DEPTH, "R6 load address in decode",
          int'(dmem_addr), m_r[(w >> 7) % 8] % DEPTH);
  endtask

  task automatic mem_chk(input int a, input int exp, input string tag);
    chk(int'(dmem[a]) == exp, tag, int'(dmem[a]), exp);
    chk(refd[a] == exp, {tag, " (model)"}, refd[a], exp);
  endtask

  // watchdog
  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    for (int k = 0; k < DEPTH; k++) begin imem[k] = '0; dmem[k] = '0; refd[k] = 0; end
    dmem[0] = 16'hDEAD; dmem[1] = 16'hBEEF; dmem[50] = 16'h1234;
    refd[0] = 'hDEAD;   refd[1] = 'hBEEF;   refd[50] = 'h1234;
    m_reset();
    p = 0;
    imem[p++] = i_ldi(1, 10);
    imem[p++] = i_ldi(2, 20);
    imem[p++] = i_rrr(1, 3, 1, 2);
    imem[p++] = i_rrr(2, 4, 3, 1);
    imem[p++] = i_st(0, 7);          // mem[0] <- R7 (cleared by reset)
    imem[p++] = i_ldi(5, 255);
    imem[p++] = i_rrr(2, 6, 1, 2);   // 10-20 wraps
    imem[p++] = i_st(5, 6);
    imem[p++] = i_rrr(1, 0, 1, 2);   // write to R0 discarded
    imem[p++] = i_ldi(7, 1);
    imem[p++] = i_st(7, 0);          // mem[1] <- R0
    imem[p++] = i_rrr(3, 6, 6, 5);
    imem[p++] = i_ldi(5, 2);
    imem[p++] = i_st(5, 6);
    imem[p++] = i_ldi(1, 255);
    imem[p++] = i_rrr(1, 2, 1, 1);   // 0x01FE
    imem[p++] = i_st(2, 1);          // address wraps to 254
    imem[p++] = i_ldi(3, 50);
    imem[p++] = i_ld(4, 3);
    imem[p++] = i_ldi(5, 3);
    imem[p++] = i_st(5, 4);
    imem[p++] = i_beq(1, 2, 5);      // not taken
    imem[p++] = i_beq(1, 1, 2);      // taken, skips next
    imem[p++] = i_st(0, 1);          // skipped
    imem[p++] = i_ldi(6, 0);
    imem[p++] = i_ldi(7, 1);
    imem[p++] = i_ldi(5, 3);
    imem[p++] = i_rrr(1, 6, 6, 7);   // loop body
    imem[p++] = i_beq(6, 5, 2);
    imem[p++] = i_beq(0, 0, -2);     // backward
    imem[p++] = i_ldi(5, 4);
    imem[p++] = i_st(5, 6);
    imem[p++] = i_jmp('h1F40);
    imem[64]  = i_ldi(5, 5);
    imem[65]  = i_st(5, 3);
    imem[66]  = i_jmp('h1F42);       // halt

    // R1: reset state
    tick();
    chk(pc_o == 16'd0, "R1 reset pc", int'(pc_o), 0);
    chk(phase_o == 2'd0, "R1 reset phase", int'(phase_o), 0);
    rst = 1'b0;
    for (int k = 0; k < 12; k++) tick();
    chk(pc_o == 16'd4, "R11 pc after 12 cycles", int'(pc_o), 4);
    chk(phase_o == 2'd0, "R11 phase after 12 cycles", int'(phase_o), 0);
    for (int k = 0; k < 228; k++) tick();

    mem_chk(0, 0, "R1 cleared register stored / R8 skipped store");
    mem_chk(1, 0, "R5 zero register as data");
    mem_chk(255, 'hFFF6, "R4 subtract wrap");
    mem_chk(2, 'h00F6, "R4 and");
    mem_chk(254, 'h00FF, "R3 zero-extended immediate, wrapped address");
    mem_chk(3, 'h1234, "R6 load");
    mem_chk(4, 3, "R8 backward loop count");
    mem_chk(5, 50, "R9 code after jump");
    chk(pc_o == 16'h1F42, "R9 jump target zero-extended", int'(pc_o), 'h1F42);

    // reset in the middle of an instruction, then rerun
    while (phase_o != 2'd1) tick();
    rst = 1'b1;
    tick();
    chk(pc_o == 16'd0 && phase_o == 2'd0, "R1 mid-run reset", int'(pc_o), 0);
    rst = 1'b0;
    for (int k = 0; k < 240; k++) tick();
    chk(pc_o == 16'h1F42, "R9 halt after rerun", int'(pc_o), 'h1F42);
    for (int k = 0; k < DEPTH; k++)
      chk(int'(dmem[k]) == refd[k], "R7 memory image", int'(dmem[k]), refd[k]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule